// File: doc/BRIEF.md
# Multiplex-Aware Display RAM Loader

This block takes a stream of display data bytes and scatters their bits into a small display memory of 4-bit words. Each word stands for one segment column. Each bit of a word stands for one backplane row. How a byte is spread depends on the multiplex drive mode. In static mode the byte goes down one row across eight columns. In duplex mode it goes down two rows across four columns. In triplex mode it goes down three rows across three columns. In quadruplex mode it goes down all four rows across two columns.

An internal data pointer marks the first column that the next byte touches. The pointer moves on by itself after every byte. A load input can set it to a new column. Partial words are updated bit by bit, so rows that a byte does not map to keep their old contents. The byte is committed on the clock edge at which its strobe is seen.

A display scanner reads any column at any time through a combinational read port.

Top module: `segram_loader`

## Requirements
- R1: While `rst` is high at a rising clock edge, the data pointer returns to column 0 and every RAM word is cleared to 0.
- R2: With `mux_mode` = 0 (static), a byte writes its bits into row 0 of 8 successive columns, MSB first. Rows 1 to 3 of those columns are unchanged, and the pointer advances by 8.
- R3: With `mux_mode` = 1 (duplex), a byte writes its bits in pairs into rows 0 and 1 of 4 successive columns. Bit 7 goes to row 0 and bit 6 to row 1 of the first column, and so on. Rows 2 and 3 are unchanged, and the pointer advances by 4.
- R4: With `mux_mode` = 2 (triplex), a byte writes its bits in triples into rows 0 to 2 of 3 successive columns. The third column receives only bits 1 and 0, in rows 0 and 1, so its rows 2 and 3 are unchanged. Row 3 of every column is never altered, and the pointer advances by 3.
- R5: With `mux_mode` = 3 (quadruplex), a byte fills rows 0 to 3 of 2 successive columns. Bits 7..4 go to rows 0..3 of the first column and bits 3..0 to rows 0..3 of the second. The pointer advances by 2.
- R6: A byte is committed on the rising edge at which `byte_vld` is high. The new contents appear on `scan_word` right after that edge, with no handshake and no extra latency.
- R7: The RAM has 40 columns. Both the pointer and the columns a byte is placed into wrap from 39 to 0.
- R8: With `ptr_load` high, the pointer takes `ptr_value`. A value of 40 or more becomes 0. If `byte_vld` is high in the same cycle, that byte is placed starting at the loaded column, and the pointer then advances from there.
- R9: `scan_word` is combinational and returns the word at `scan_addr`, with row r on bit r. An address of 40 or more reads as 0.
- R10: In cycles with `byte_vld` and `ptr_load` both low, neither the RAM contents nor the pointer change, whatever `byte_data` and `mux_mode` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Byte strobe: commit `byte_data` this edge |
| byte_data | input | 8 | Display data byte |
| mux_mode | input | 2 | 0 static, 1 duplex, 2 triplex, 3 quadruplex |
| ptr_load | input | 1 | Load the data pointer from `ptr_value` |
| ptr_value | input | 6 | New pointer column |
| scan_addr | input | 6 | Scanner column address |
| scan_word | output | 4 | Word at `scan_addr`, row r on bit r |

## Verification
Every byte and every pointer load takes effect on the single rising edge at which its strobe is high. The bench drives inputs on the falling edge and reads the scan port at the next falling edge, so each check lands exactly one edge after its stimulus. Since the read port is combinational, a check can also sample just before the committing edge to show that the old word is still there, and then just after it to show the new word. Pointer movement has no port of its own, so it is judged by the column where the next byte lands. A bench model built from the placement rules tracks all 40 words for full-memory comparisons.

// File: rtl/segram_pkg.sv
package segram_pkg;

  typedef enum logic [1:0] {
    MX_STATIC = 2'd0,
    MX_DUO    = 2'd1,
    MX_TRI    = 2'd2,
    MX_QUAD   = 2'd3
  } mx_mode_e;

  // rows of a column filled by one byte in a given mode
  function automatic int seg_rows(input logic [1:0] m);
    return int'(m) + 1;
  endfunction

  // columns a byte spans, i.e. the pointer step: ceil(bw / rows)
  function automatic int seg_advance(input logic [1:0] m, input int bw);
    case (mx_mode_e'(m))
      MX_STATIC: return bw;
      MX_DUO:    return (bw + 1) / 2;
      MX_TRI:    return (bw + 2) / 3;
      default:   return (bw + 3) / 4;
    endcase
  endfunction

endpackage

// File: rtl/segram_place.sv
// Maps each byte bit to a (slot, row); slot s targets column base+s (wrapped).
module segram_place
  import segram_pkg::*;
#(
  parameter int NUM_COLS = 40,
  parameter int ROWS     = 4,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 6
) (
  input  logic [1:0]                        mode,
  input  logic [BYTE_W-1:0]                 data,
  input  logic [ADDR_W-1:0]                 base,
  output logic [BYTE_W-1:0][ADDR_W-1:0]     slot_col,
  output logic [BYTE_W-1:0][ROWS-1:0]       slot_mask,
  output logic [BYTE_W-1:0][ROWS-1:0]       slot_bits
);

  localparam int SUM_W = ADDR_W + 1;

  always_comb begin
    int k;
    int idx;
    logic [SUM_W-1:0] sum;
    k = seg_rows(mode);
    for (int s = 0; s < BYTE_W; s++) begin
      sum = {1'b0, base} + SUM_W'(s);
      if (sum >= SUM_W'(NUM_COLS)) sum = sum - SUM_W'(NUM_COLS);
      slot_col[s] = sum[ADDR_W-1:0];
      for (int r = 0; r < ROWS; r++) begin
        idx = s * k + r;
        slot_mask[s][r] = 1'b0;
        slot_bits[s][r] = 1'b0;
        if (r < k && idx < BYTE_W) begin
          slot_mask[s][r] = 1'b1;
          slot_bits[s][r] = data[BYTE_W-1-idx];
        end
      end
    end
  end

endmodule

// File: rtl/segram_ptr.sv
// Data pointer: optional load (clamped), auto-advance per byte, wraparound.
module segram_ptr
  import segram_pkg::*;
#(
  parameter int NUM_COLS = 40,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] ptr_q
);

  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] clamp_val;
  logic [SUM_W-1:0]  nxt;

  assign clamp_val = (load_val >= ADDR_W'(NUM_COLS)) ? '0 : load_val;
  assign base      = load ? clamp_val : ptr_q;

  always_comb begin
    nxt = {1'b0, base} + SUM_W'(seg_advance(mode, BYTE_W));
    if (nxt >= SUM_W'(NUM_COLS)) nxt = nxt - SUM_W'(NUM_COLS);
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (adv)  ptr_q <= nxt[ADDR_W-1:0];
    else if (load) ptr_q <= clamp_val;
  end

endmodule

// File: rtl/segram_store.sv
// Column store with per-bit write enables and a combinational scan read.
module segram_store #(
  parameter int NUM_COLS = 40,
  parameter int ROWS     = 4,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [BYTE_W-1:0][ADDR_W-1:0] slot_col,
  input  logic [BYTE_W-1:0][ROWS-1:0]   slot_mask,
  input  logic [BYTE_W-1:0][ROWS-1:0]   slot_bits,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [ROWS-1:0]               rd_word,
  output logic [NUM_COLS*ROWS-1:0]      mem_flat
);

  logic [NUM_COLS-1:0][ROWS-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we) begin
      for (int w = 0; w < NUM_COLS; w++)
        for (int s = 0; s < BYTE_W; s++)
          for (int r = 0; r < ROWS; r++)
            if (slot_col[s] == ADDR_W'(w) && slot_mask[s][r])
              mem[w][r] <= slot_bits[s][r];
    end
  end

  assign rd_word  = (rd_addr < ADDR_W'(NUM_COLS)) ? mem[rd_addr] : '0;
  assign mem_flat = mem;

endmodule

// File: rtl/segram_loader.sv
module segram_loader #(
  parameter int NUM_COLS = 40,
  parameter int ROWS     = 4,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [1:0]        mux_mode,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_value,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [ROWS-1:0]   scan_word
);

  logic [ADDR_W-1:0]             base;
  logic [ADDR_W-1:0]             ptr_q;
  logic [BYTE_W-1:0][ADDR_W-1:0] slot_col;
  logic [BYTE_W-1:0][ROWS-1:0]   slot_mask;
  logic [BYTE_W-1:0][ROWS-1:0]   slot_bits;
  logic [NUM_COLS*ROWS-1:0]      mem_flat;

  segram_ptr #(.NUM_COLS(NUM_COLS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_value),
    .adv(byte_vld), .mode(mux_mode), .base(base), .ptr_q(ptr_q)
  );

  segram_place #(.NUM_COLS(NUM_COLS), .ROWS(ROWS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_place (
    .mode(mux_mode), .data(byte_data), .base(base),
    .slot_col(slot_col), .slot_mask(slot_mask), .slot_bits(slot_bits)
  );

  segram_store #(.NUM_COLS(NUM_COLS), .ROWS(ROWS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .we(byte_vld),
    .slot_col(slot_col), .slot_mask(slot_mask), .slot_bits(slot_bits),
    .rd_addr(scan_addr), .rd_word(scan_word), .mem_flat(mem_flat)
  );

endmodule

// File: rtl/segram_loader_chk.sv
module segram_loader_chk #(
  parameter int NUM_COLS = 40,
  parameter int ROWS     = 4,
  parameter int ADDR_W   = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     byte_vld,
  input logic [1:0]               mux_mode,
  input logic                     ptr_load,
  input logic [ADDR_W-1:0]        ptr_value,
  input logic [ADDR_W-1:0]        scan_addr,
  input logic [ROWS-1:0]          scan_word,
  input logic [ADDR_W-1:0]        ptr_q,
  input logic [NUM_COLS*ROWS-1:0] mem_flat
);

  logic [ROWS-1:0][NUM_COLS-1:0] rowv;

  always_comb
    for (int w = 0; w < NUM_COLS; w++)
      for (int r = 0; r < ROWS; r++)
        rowv[r][w] = mem_flat[w*ROWS + r];

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ptr_q == '0 && mem_flat == '0));                                   // R1
  AST_STATIC_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && mux_mode == 2'd0) |=> ($stable(rowv[1]) && $stable(rowv[2]) && $stable(rowv[3]))); // R2
  AST_DUO_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && mux_mode == 2'd1) |=> ($stable(rowv[2]) && $stable(rowv[3]))); // R3
  AST_TRI_KEEPS_ROW3: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && mux_mode == 2'd2) |=> $stable(rowv[3]));                       // R4
  AST_QUAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !ptr_load && mux_mode == 2'd3) |=>
      (int'(ptr_q) == (int'($past(ptr_q)) + 2) % NUM_COLS));                    // R5
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(ptr_q) < NUM_COLS);                                                    // R7
  AST_LOAD_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && !byte_vld) |=>
      (int'(ptr_q) == ((int'($past(ptr_value)) >= NUM_COLS) ? 0 : int'($past(ptr_value))))); // R8
  AST_SCAN_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(scan_addr) >= NUM_COLS) |-> (scan_word == '0));                       // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!byte_vld && !ptr_load) |=> ($stable(ptr_q) && $stable(mem_flat)));        // R10

endmodule

bind segram_loader segram_loader_chk #(
  .NUM_COLS(NUM_COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .byte_vld(byte_vld), .mux_mode(mux_mode),
  .ptr_load(ptr_load), .ptr_value(ptr_value), .scan_addr(scan_addr),
  .scan_word(scan_word), .ptr_q(ptr_q), .mem_flat(mem_flat)
);

// File: tb/segram_loader_tb.sv
`timescale 1ns/1ps
module segram_loader_tb;

  localparam int NC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic [1:0] mux_mode = '0;
  logic       ptr_load = 1'b0;
  logic [5:0] ptr_value = '0;
  logic [5:0] scan_addr = '0;
  logic [3:0] scan_word;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] mdl [NC];
  int mptr = 0;

  // stimulus table: {load, load value, mode, data}
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 6'd0,  2'd0, 8'hC3},
    {1'b0, 6'd0,  2'd1, 8'h96},
    {1'b0, 6'd0,  2'd2, 8'h5B},
    {1'b0, 6'd0,  2'd3, 8'hE1},
    {1'b1, 6'd35, 2'd0, 8'h7E},
    {1'b0, 6'd0,  2'd2, 8'hFF},
    {1'b1, 6'd37, 2'd2, 8'h24},
    {1'b1, 6'd63, 2'd1, 8'hA9},
    {1'b0, 6'd0,  2'd3, 8'h4D},
    {1'b0, 6'd0,  2'd0, 8'h00}
  };

  segram_loader u_dut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .mux_mode(mux_mode), .ptr_load(ptr_load), .ptr_value(ptr_value),
    .scan_addr(scan_addr), .scan_word(scan_word)
  );

  always #2.5 clk = ~clk;

  task automatic model_byte(input bit ld, input logic [5:0] v, input logic [1:0] m,
                            input logic [7:0] d);
    int k;
    int col;
    if (ld) mptr = (int'(v) >= NC) ? 0 : int'(v);
    k = int'(m) + 1;
    for (int i = 0; i < 8; i++) begin
      col = (mptr + i / k) % NC;
      mdl[col][i % k] = d[7-i];
    end
    mptr = (mptr + (8 + k - 1) / k) % NC;
  endtask

  task automatic push(input bit ld, input logic [5:0] v, input logic [1:0] m,
                      input logic [7:0] d);
    @(negedge clk);
    byte_vld = 1'b1; ptr_load = ld; ptr_value = v; mux_mode = m; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0; ptr_load = 1'b0;
    model_byte(ld, v, m, d);
  endtask

  task automatic check_word(input int col, input logic [3:0] exp, input string tag);
    scan_addr = 6'(col);
    #0.5;
    n_checks++;
    if (scan_word !== exp) begin
      n_fails++;
      $display("FAIL %s col %0d: actual %h expected %h", tag, col, scan_word, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int bad;
    int bad_col;
    logic [3:0] bad_val;
    bad = 0; bad_col = 0; bad_val = '0;
    for (int c = 0; c < NC; c++) begin
      scan_addr = 6'(c);
      #0.1;
      if (scan_word !== mdl[c] && bad == 0) begin
        bad = 1; bad_col = c; bad_val = scan_word;
      end
    end
    n_checks++;
    if (bad != 0) begin
      n_fails++;
      $display("FAIL %s col %0d: actual %h expected %h", tag, bad_col, bad_val, mdl[bad_col]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_word(0, 4'h0, "R1 reset word");
    check_all("R1 reset memory");

    // table walk: R6 commit on the strobe edge, placement R2..R5, R7, R8
    for (int v = 0; v < 10; v++) begin
      push(VEC[v][16], VEC[v][15:10], VEC[v][9:8], VEC[v][7:0]);
      check_all($sformatf("R6 table vector %0d", v));
    end

    // R2 static keeps upper rows
    push(1'b1, 6'd30, 2'd3, 8'hF0);
    push(1'b1, 6'd30, 2'd0, 8'h5A);
    check_word(30, 4'hE, "R2 static row0 cleared");
    check_word(31, 4'h1, "R2 static row0 set");

    // R3 duplex pairs and step of 4
    push(1'b1, 6'd12, 2'd3, 8'hFF);
    push(1'b1, 6'd12, 2'd1, 8'h12);
    check_word(12, 4'hC, "R3 duplex first pair");
    check_word(13, 4'hE, "R3 duplex second pair");
    push(1'b0, 6'd0, 2'd1, 8'hC0);
    check_word(16, mdl[16], "R3 duplex step 4");
    check_all("R3 duplex memory");

    // R4 triplex triples, third column rows 2..3 untouched, step of 3
    push(1'b1, 6'd20, 2'd3, 8'hFF);
    push(1'b0, 6'd0,  2'd3, 8'hFF);
    push(1'b1, 6'd20, 2'd2, 8'h00);
    check_word(20, 4'h8, "R4 triplex col0");
    check_word(21, 4'h8, "R4 triplex col1");
    check_word(22, 4'hC, "R4 triplex third keeps rows 2-3");
    check_word(23, 4'hF, "R4 triplex beyond span");
    push(1'b0, 6'd0, 2'd2, 8'h00);
    check_word(23, 4'h8, "R4 triplex step 3");

    // R5 quadruplex
    push(1'b1, 6'd10, 2'd3, 8'h3C);
    check_word(10, 4'hC, "R5 quad high nibble");
    check_word(11, 4'h3, "R5 quad low nibble");

    // R7 wraparound of placement and pointer
    push(1'b1, 6'd39, 2'd3, 8'hF0);
    check_word(39, 4'hF, "R7 last column");
    check_word(0,  4'h0, "R7 wrapped column");
    push(1'b0, 6'd0, 2'd3, 8'hFF);
    check_word(1, 4'hF, "R7 pointer wrapped to 1");

    // R8 clamp of an out-of-range load together with a byte
    push(1'b1, 6'd50, 2'd3, 8'h81);
    check_word(0, 4'h1, "R8 clamped load col0");
    check_word(1, 4'h8, "R8 clamped load col1");

    // R9 out-of-range scan
    check_word(45, 4'h0, "R9 scan addr 45");
    check_word(63, 4'h0, "R9 scan addr 63");

    // R10 idle cycles with busy data lines change nothing
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      byte_data = 8'(8'h3B * (i + 1)); mux_mode = 2'(i); ptr_value = 6'(i * 7);
      @(negedge clk);
    end
    check_all("R10 idle memory");
    push(1'b0, 6'd0, 2'd3, 8'h69);
    check_all("R10 idle pointer");

    // R6 timing: old word before the edge, new word right after it
    scan_addr = 6'd5;
    @(negedge clk);
    byte_vld = 1'b1; ptr_load = 1'b1; ptr_value = 6'd5; mux_mode = 2'd3;
    byte_data = ~{mdl[5][0], mdl[5][1], mdl[5][2], mdl[5][3], 4'h0};
    #1;
    n_checks++;
    if (scan_word !== mdl[5]) begin
      n_fails++;
      $display("FAIL R6 before edge: actual %h expected %h", scan_word, mdl[5]);
    end
    @(negedge clk);
    byte_vld = 1'b0; ptr_load = 1'b0;
    model_byte(1'b1, 6'd5, 2'd3, byte_data);
    check_word(5, mdl[5], "R6 after edge");
    check_all("R6 final memory");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule